// File: doc/BRIEF.md
# Sequential Signed Fractional Divider

This block divides one signed fixed-point fraction by another over several clock cycles. Every operand and result is a two's complement fraction whose binary point lies just right of the sign bit. The dividend is 71 bits wide. The divisor, the quotient and the remainder are 36 bits wide. The divisor's binary point is aligned with the dividend's binary point. The least significant bit of the remainder therefore carries the same weight as the least significant bit of the dividend.

A one-cycle `start` pulse while the block is idle captures both operands. The block removes the signs, forms the magnitudes and checks whether the quotient can be represented. It then runs a restoring shift-and-subtract loop that produces one quotient bit per cycle. At the end it applies the signs and pulses `done`. If the divisor is zero, or if the quotient would not fit, the block skips the loop and raises `div_check` instead.

In integer terms, let Dm be the magnitude of the dividend read as an unsigned integer and Sm the magnitude of the divisor read the same way. The quotient magnitude is then floor(Dm / Sm) and the remainder magnitude is Dm mod Sm.

Top module: `frac_divider`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `done`, `div_check`, `quotient` and `remainder` are all zero.
- R2: A `start` seen at a clock edge while `busy` is low is accepted and sets `busy` from that edge. For valid operands, `done` is high for exactly one cycle, starting 36 edges after the accepting edge. `busy` falls at the same edge at which `done` rises.
- R3: `div_check` goes high with `done` one edge after acceptance in two cases: the divisor magnitude is zero, or Dm >> 35 (the upper 36 bits of the 71-bit magnitude) is greater than or equal to Sm. In both cases `quotient` and `remainder` keep their previous values.
- R4: For valid operands the quotient magnitude equals floor(Dm / Sm).
- R5: The quotient is negative exactly when the dividend sign bit (bit 70) differs from the divisor sign bit (bit 35). A zero quotient magnitude is output as all zeros.
- R6: The remainder magnitude equals Dm mod Sm. A nonzero remainder carries the dividend's sign.
- R7: A zero remainder is output as all zeros, even when the dividend is negative.
- R8: A `start` pulse while `busy` is high is ignored. The running operation finishes with its own operands and its own timing.
- R9: The most negative encodings are treated as magnitude 1.0. For the dividend this is Dm = 2^70, and for the divisor Sm = 2^35.
- R10: `div_check`, `quotient` and `remainder` hold their values between operations. `div_check` clears at the `done` of the next valid operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; operands are sampled with it |
| dividend | input | 71 | Signed fractional dividend |
| divisor | input | 36 | Signed fractional divisor |
| busy | output | 1 | High while an accepted operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 36 | Signed fractional quotient |
| remainder | output | 36 | Signed fractional remainder |
| div_check | output | 1 | Divide check: zero divisor or quotient overflow |

## Verification
The hardest cases to reach are the edge of the overflow test and the most negative operands. Uniformly random operands almost never land where the upper dividend bits come within one unit of the divisor magnitude. They also almost never yield an exact zero remainder from a negative dividend.

The stimulus therefore builds these operands directly. The overflow edge is reached by placing Sm-1 and then Sm in the dividend's upper field. An exact multiple of the divisor is negated to give a zero remainder from a negative dividend. Directed cases also pair minus one with the largest positive value.

A second `start` is injected halfway through a running operation. Random operands of varied scale fill in the sign combinations. A behavioural model checks every cycle of every operation.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } fd_state_e;
endpackage

// File: rtl/fd_operand_prep.sv
module fd_operand_prep #(
  parameter int DVD_W = 71,
  parameter int DVS_W = 36
) (
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] dvd_mag,
  output logic [DVS_W-1:0] dvs_mag,
  output logic             dvd_neg,
  output logic             quo_neg,
  output logic             bad_op
);
  localparam int LO_W = DVD_W - DVS_W;

  logic [DVS_W-1:0] upper;

  always_comb begin
    dvd_neg = dividend[DVD_W-1];
    quo_neg = dividend[DVD_W-1] ^ divisor[DVS_W-1];
    // two's complement magnitude; the most negative code maps to 1.0
    dvd_mag = dvd_neg ? (~dividend + 1'b1) : dividend;
    dvs_mag = divisor[DVS_W-1] ? (~divisor + 1'b1) : divisor;
    upper   = dvd_mag[DVD_W-1:LO_W];
    bad_op  = (dvs_mag == '0) || (upper >= dvs_mag);
  end
endmodule

// File: rtl/fd_step.sv
module fd_step #(
  parameter int W = 36
) (
  input  logic [W-1:0] part,
  input  logic         in_bit,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] part_nxt,
  output logic         q_bit
);
  logic [W:0] shifted;
  logic [W:0] trial;

  always_comb begin
    shifted  = {part, in_bit};
    trial    = shifted - {1'b0, dvs};
    q_bit    = (shifted >= {1'b0, dvs});
    part_nxt = q_bit ? trial[W-1:0] : shifted[W-1:0];
  end
endmodule

// File: rtl/fd_sign_fix.sv
module fd_sign_fix #(
  parameter int W = 36
) (
  input  logic [W-1:0] q_mag,
  input  logic [W-1:0] r_mag,
  input  logic         q_neg,
  input  logic         r_neg,
  output logic [W-1:0] q_out,
  output logic [W-1:0] r_out
);
  always_comb begin
    q_out = q_neg ? (~q_mag + 1'b1) : q_mag;
    if (r_neg && (r_mag != '0)) r_out = ~r_mag + 1'b1;
    else                        r_out = r_mag;
  end
endmodule

// File: rtl/frac_divider.sv
module frac_divider #(
  parameter int DVD_W = 71,
  parameter int DVS_W = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVS_W-1:0] quotient,
  output logic [DVS_W-1:0] remainder,
  output logic             div_check
);
  import frac_div_pkg::*;

  localparam int FRAC_W = DVS_W - 1;
  localparam int LO_W   = DVD_W - DVS_W;
  localparam int CNT_W  = (FRAC_W > 1) ? $clog2(FRAC_W) : 1;

  fd_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [DVS_W-1:0] part_r, quo_r, dvs_r;
  logic [LO_W-1:0]  low_r;
  logic             qneg_r, rneg_r, bad_r;

  logic [DVD_W-1:0] dvd_mag;
  logic [DVS_W-1:0] dvs_mag, part_nxt, q_fix, r_fix;
  logic             dvd_neg, quo_neg, bad_op, q_bit;

  fd_operand_prep #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_prep (
    .dividend(dividend), .divisor(divisor), .dvd_mag(dvd_mag),
    .dvs_mag(dvs_mag), .dvd_neg(dvd_neg), .quo_neg(quo_neg), .bad_op(bad_op)
  );

  fd_step #(.W(DVS_W)) u_step (
    .part(part_r), .in_bit(low_r[LO_W-1]), .dvs(dvs_r),
    .part_nxt(part_nxt), .q_bit(q_bit)
  );

  fd_sign_fix #(.W(DVS_W)) u_fix (
    .q_mag(quo_r), .r_mag(part_r), .q_neg(qneg_r), .r_neg(rneg_r),
    .q_out(q_fix), .r_out(r_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      part_r    <= '0;
      quo_r     <= '0;
      dvs_r     <= '0;
      low_r     <= '0;
      qneg_r    <= 1'b0;
      rneg_r    <= 1'b0;
      bad_r     <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_check <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            part_r <= dvd_mag[DVD_W-1:LO_W];
            low_r  <= dvd_mag[LO_W-1:0];
            dvs_r  <= dvs_mag;
            quo_r  <= '0;
            qneg_r <= quo_neg;
            rneg_r <= dvd_neg;
            bad_r  <= bad_op;
            cnt    <= '0;
            busy   <= 1'b1;
            state  <= bad_op ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          part_r <= part_nxt;
          quo_r  <= {quo_r[DVS_W-2:0], q_bit};
          low_r  <= low_r << 1;
          cnt    <= cnt + 1'b1;
          if (cnt == CNT_W'(FRAC_W - 1)) state <= ST_FIN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
          if (bad_r) begin
            div_check <= 1'b1;
          end else begin
            div_check <= 1'b0;
            quotient  <= q_fix;
            remainder <= r_fix;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
  parameter int DVD_W = 71,
  parameter int DVS_W = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [DVD_W-1:0] dividend,
  input logic [DVS_W-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [DVS_W-1:0] quotient,
  input logic [DVS_W-1:0] remainder,
  input logic             div_check
);
  logic neg_l, qsg_l, zdiv_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_l <= 1'b0; qsg_l <= 1'b0; zdiv_l <= 1'b0;
    end else if (start && !busy) begin
      neg_l  <= dividend[DVD_W-1];
      qsg_l  <= dividend[DVD_W-1] ^ divisor[DVS_W-1];
      zdiv_l <= (divisor == '0);
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_zero_div_R3: assert property (@(posedge clk) disable iff (rst)
    (done && zdiv_l) |-> div_check);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (done && div_check) |-> ($stable(quotient) && $stable(remainder)));
  assert_quo_sign_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !div_check && quotient != '0) |-> (quotient[DVS_W-1] == qsg_l));
  assert_rem_sign_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !div_check && remainder != '0) |-> (remainder[DVS_W-1] == neg_l));
  assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(div_check) || done));
endmodule

bind frac_divider fd_checker #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
  .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
  .div_check(div_check)
);

// File: tb/frac_divider_test.sv
module frac_divider_test;
  localparam int DVD_W = 71;
  localparam int DVS_W = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [DVD_W-1:0] dividend = '0;
  logic [DVS_W-1:0] divisor = '0;
  logic busy, done, div_check;
  logic [DVS_W-1:0] quotient, remainder;

  always #2 clk = ~clk;

  frac_divider #(.DVD_W(DVD_W), .DVS_W(DVS_W)) uut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .div_check(div_check)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input logic [DVD_W-1:0] act,
                     input logic [DVD_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated at each edge, compared between edges
  logic m_busy = 0, m_done = 0, m_chk = 0;
  logic [DVS_W-1:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;
  logic p_bad = 0;
  int m_cnt = 0;

  task automatic ref_div(input logic [DVD_W-1:0] dd, input logic [DVS_W-1:0] ds,
                         output logic bad, output logic [DVS_W-1:0] q,
                         output logic [DVS_W-1:0] r);
    logic [DVD_W-1:0] dm, sm, qm, rm;
    dm = dd[DVD_W-1] ? -dd : dd;
    sm = {{(DVD_W-DVS_W){1'b0}}, (ds[DVS_W-1] ? -ds : ds)};
    bad = (sm == 0) || ((dm >> (DVD_W - DVS_W)) >= sm);
    qm = (sm == 0) ? '0 : dm / sm;
    rm = (sm == 0) ? '0 : dm % sm;
    q = (dd[DVD_W-1] ^ ds[DVS_W-1]) ? -qm[DVS_W-1:0] : qm[DVS_W-1:0];
    r = (dd[DVD_W-1] && rm != 0) ? -rm[DVS_W-1:0] : rm[DVS_W-1:0];
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_chk = 0; m_q = '0; m_r = '0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m_busy = 0; m_chk = p_bad;
          if (!p_bad) begin m_q = p_q; m_r = p_r; end
        end
      end else if (start) begin
        ref_div(dividend, divisor, p_bad, p_q, p_r);
        m_busy = 1;
        m_cnt = p_bad ? 1 : DVS_W;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == m_busy && done == m_done, "R2 handshake",
          {busy, done}, {m_busy, m_done});
      chk(quotient == m_q, "R4 quotient", quotient, m_q);
      chk(remainder == m_r, "R6 remainder", remainder, m_r);
      chk(div_check == m_chk, "R3 div_check", div_check, m_chk);
    end
  end

  task automatic issue(input logic [DVD_W-1:0] dd, input logic [DVS_W-1:0] ds);
    while (busy) @(negedge clk);
    dividend = dd; divisor = ds; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done;
    do @(negedge clk); while (!done);
  endtask

  task automatic op(input logic [DVD_W-1:0] dd, input logic [DVS_W-1:0] ds);
    issue(dd, ds);
    wait_done();
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 150000) begin
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [DVS_W-1:0] MINUS_ONE_S = {1'b1, {(DVS_W-1){1'b0}}};
  localparam logic [DVD_W-1:0] MINUS_ONE_D = {1'b1, {(DVD_W-1){1'b0}}};
  localparam logic [DVD_W-1:0] MAX_D = {1'b0, {(DVD_W-1){1'b1}}};

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && div_check == 0, "R1 reset flags",
        {busy, done, div_check}, '0);
    chk(quotient == 0 && remainder == 0, "R1 reset data", {quotient, remainder}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && quotient == 0, "R1 after reset", {busy, done}, '0);

    // sign combinations, 1000 / 7 = 142 rem 6
    op(71'd1000, 36'd7);
    chk(quotient == 36'd142 && remainder == 36'd6, "R4 +/+", {quotient, remainder}, {36'd142, 36'd6});
    op(71'd1000, -36'd7);
    chk(quotient == -36'd142, "R5 +/-", quotient, -36'd142);
    chk(remainder == 36'd6, "R6 +/- rem", remainder, 36'd6);
    op(-71'd1000, 36'd7);
    chk(quotient == -36'd142 && remainder == -36'd6, "R6 -/+", {quotient, remainder}, {-36'd142, -36'd6});
    op(-71'd1000, -36'd7);
    chk(quotient == 36'd142 && remainder == -36'd6, "R5 -/-", {quotient, remainder}, {36'd142, -36'd6});

    // zero quotient with negative sign
    op(-71'd3, 36'd5);
    chk(quotient == 0, "R5 zero quotient", quotient, 0);
    chk(remainder == -36'd3, "R6 small rem", remainder, -36'd3);

    // zero remainder from negative dividend
    op(-71'd15, 36'd5);
    chk(quotient == -36'd3 && remainder == 0, "R7 zero rem", {quotient, remainder}, {-36'd3, 36'd0});

    // largest magnitudes
    op(MAX_D, MINUS_ONE_S);
    chk(quotient == 36'h8_0000_0001 && remainder == 36'h7_FFFF_FFFF, "R9 max by -1",
        {quotient, remainder}, {36'h8_0000_0001, 36'h7_FFFF_FFFF});
    op(MINUS_ONE_D, MINUS_ONE_S);
    chk(div_check == 1, "R9 -1 by -1 check", div_check, 1);
    chk(quotient == 36'h8_0000_0001, "R3 hold after overflow", quotient, 36'h8_0000_0001);

    // overflow boundary with divisor 1000
    op({36'd999, {(DVD_W-DVS_W){1'b1}}}, 36'd1000);
    chk(div_check == 0, "R10 check cleared", div_check, 0);
    chk(quotient == 36'h7_FFFF_FFFF && remainder == 36'd999, "R4 boundary fits",
        {quotient, remainder}, {36'h7_FFFF_FFFF, 36'd999});
    op({36'd1000, {(DVD_W-DVS_W){1'b0}}}, 36'd1000);
    chk(div_check == 1, "R3 boundary overflow", div_check, 1);
    op(71'd12, 36'd0);
    chk(div_check == 1, "R3 zero divisor", div_check, 1);
    chk(remainder == 36'd999, "R3 hold remainder", remainder, 36'd999);
    repeat (3) @(negedge clk);
    chk(div_check == 1, "R10 flag held", div_check, 1);

    // start while busy ignored
    issue(71'd100, 36'd7);
    repeat (5) @(negedge clk);
    dividend = 71'd50; divisor = 36'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(quotient == 36'd14 && remainder == 36'd2, "R8 ignored start",
        {quotient, remainder}, {36'd14, 36'd2});

    // random operands of varied scale
    for (int i = 0; i < 200; i++) begin
      logic [DVD_W-1:0] dd;
      logic [DVS_W-1:0] ds;
      dd = {$urandom, $urandom, $urandom};
      dd = dd >> ($urandom % 50);
      if ($urandom % 2) dd = -dd;
      ds = {$urandom, $urandom};
      ds = ds >> ($urandom % 30);
      if ($urandom % 2) ds = -ds;
      op(dd, ds);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule